// File: doc/BRIEF.md
# Free-Running System Timer with Single Compare Interrupt

This block is a memory-mapped system timer. A 64-bit counter runs freely from reset and advances by one on every clock cycle in which the tick-enable input is high. Software sees the counter as two 32-bit words. A single 32-bit compare register is checked against the low word of the counter. When the two are equal on a tick cycle and comparison is enabled, a sticky match flag sets and drives a level interrupt request.

Software reaches the timer over a simple single-cycle register bus. Writes take effect at the next clock edge. Reads return data combinationally in the same cycle as the read strobe. No snapshot ties the two counter words together, so software reads high, low, then high again and retries when the two high reads differ. A typical handler clears the flag and the enable in one write to the control word, then loads a new compare value and enables again.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the counter (both words), the compare register, the match flag, the compare enable and `irq` are all zero.
- R2: The counter low word increases by exactly one on each clock edge where `tick_en` is high and holds its value otherwise.
- R3: The counter high word increases by one on the same edge where the low word wraps from all ones to zero, and holds otherwise.
- R4: Writes to the counter word offsets 0x04 (low) and 0x08 (high) have no effect; both read back unchanged.
- R5: The compare register at offset 0x0C is read/write over its full width.
- R6: When the compare enable is 1, `tick_en` is high and the counter low word equals the compare value, the match flag (control bit 0) is 1 after that edge; when the enable is 0, a clear flag stays clear.
- R7: The match flag stays set until software writes the control word (offset 0x00) with bit 0 equal to 1; a write with bit 0 equal to 0 leaves it set.
- R8: When a match and a write-1 clear of bit 0 fall on the same edge, the flag ends up set.
- R9: `irq` is high exactly while the match flag is set.
- R10: Control bit 4 is the compare enable and reads back as written; all other control bits read as zero.
- R11: Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C (including misaligned ones) return zero, and `bus_rdata` is zero whenever `bus_re` is low.
- R12: A single control write of 0x01 clears both the flag and the enable, after which the counter passing the compare value raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advances the counter by one when high |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WORD_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | WORD_W | Read data, valid in the cycle of `bus_re` |
| irq | output | 1 | Level interrupt request, high while the match flag is set |

## Verification
On every cycle the assertions check counter arithmetic: the low word steps by one only on ticks, and the high word carries only on low-word wrap. They also check that a qualifying match always leaves the interrupt raised, that a raised interrupt survives any cycle without a write-1 clear, and that a disabled compare never raises it. Register read-back, ignored writes to the counter words, zero reads of unmapped offsets, and same-edge set/clear priority are shown by the bench's scenarios. So are the one-write shutdown and the high-word carry, which is observed on a narrow-word instance that wraps in 256 ticks.

// File: rtl/tmr_pkg.sv
// Package tmr_pkg
// Shared constants for the system timer: register offsets and control bit
// positions. Assumes byte addressing with word-aligned registers.
package tmr_pkg;

    // Byte offsets of the four registers
    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_CNT_LO = 4;
    localparam int unsigned OFS_CNT_HI = 8;
    localparam int unsigned OFS_CMP    = 12;

    // Control word bit positions
    localparam int unsigned FLAG_BIT = 0;
    localparam int unsigned ENA_BIT  = 4;

    // Register selector decoded from the address
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_CNT_LO = 2'd1,
        SEL_CNT_HI = 2'd2,
        SEL_CMP    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/tmr_counter.sv
// Module tmr_counter
// Two-word free-running counter. The low word advances on each tick; the
// high word advances in the same edge when the low word wraps.
// Assumes: synchronous active-low reset, tick_en already synchronous.
module tmr_counter #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [WORD_W-1:0] cnt_lo,
    output logic [WORD_W-1:0] cnt_hi
);

    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    logic lo_full;

    // Detect that the next tick will wrap the low word
    always_comb begin
        lo_full = &cnt_lo;
    end

    // Advance the low word per tick and carry into the high word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (tick_en) begin
            cnt_lo <= cnt_lo + ONE;
            if (lo_full) begin
                cnt_hi <= cnt_hi + ONE;
            end
        end
    end

endmodule

// File: rtl/tmr_compare.sv
// Module tmr_compare
// Compare register, compare enable and sticky match flag. A match is an
// enabled tick cycle on which the counter low word equals the compare value.
// A match on the same edge as a write-1 clear leaves the flag set.
// Assumes: write strobes are single-cycle pulses from the register decoder.
module tmr_compare #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic              ctrl_wr,
    input  logic              clr_bit,
    input  logic              ena_bit,
    input  logic              cmp_wr,
    input  logic [WORD_W-1:0] cmp_wdata,
    output logic [WORD_W-1:0] cmp_val,
    output logic              ena,
    output logic              flag
);

    logic match_hit;
    logic clr_req;

    // Qualify the equality with enable and tick; build the clear request
    always_comb begin
        match_hit = ena && tick_en && (cnt_lo == cmp_val);
        clr_req   = ctrl_wr && clr_bit;
    end

    // Hold the compare value written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val <= '0;
        end else if (cmp_wr) begin
            cmp_val <= cmp_wdata;
        end
    end

    // Hold the compare enable written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena <= 1'b0;
        end else if (ctrl_wr) begin
            ena <= ena_bit;
        end
    end

    // Sticky match flag: set has priority over write-1 clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (match_hit) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_regbus.sv
// Module tmr_regbus
// Address decoder and read multiplexer for the timer's four word registers.
// Produces write strobes for the writable registers and returns read data
// in the same cycle as the read strobe. Offsets outside the map and
// misaligned offsets decode to nothing and read as zero.
// Assumes: ADDR_W >= 4.
module tmr_regbus
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WORD_W = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic [WORD_W-1:0] cnt_hi,
    input  logic [WORD_W-1:0] cmp_val,
    output logic              ctrl_wr,
    output logic              cmp_wr,
    output logic [WORD_W-1:0] bus_rdata
);

    localparam int unsigned MAP_BYTES = OFS_CMP + 4;

    logic     in_map;
    reg_sel_e sel;

    // Decide whether the address names a mapped, aligned register
    always_comb begin
        in_map = (bus_addr < ADDR_W'(MAP_BYTES)) && (bus_addr[1:0] == 2'b00);
        sel    = reg_sel_e'(bus_addr[3:2]);
    end

    // Generate write strobes; counter words have no strobe
    always_comb begin
        ctrl_wr = bus_we && in_map && (sel == SEL_CTRL);
        cmp_wr  = bus_we && in_map && (sel == SEL_CMP);
    end

    // Select read data; zero when idle or unmapped
    always_comb begin
        bus_rdata = '0;
        if (bus_re && in_map) begin
            unique case (sel)
                SEL_CTRL:   bus_rdata = ctrl_word;
                SEL_CNT_LO: bus_rdata = cnt_lo;
                SEL_CNT_HI: bus_rdata = cnt_hi;
                SEL_CMP:    bus_rdata = cmp_val;
            endcase
        end
    end

endmodule

// File: rtl/sys_tick_timer.sv
// Module sys_tick_timer
// Top of the system timer: free-running two-word counter, one compare
// channel on the low word with a sticky match flag, and a level interrupt.
// Assumes: single-cycle register bus, byte offsets, WORD_W >= 5 so that the
// enable bit fits in the control word.
module sys_tick_timer
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);

    logic [WORD_W-1:0] cnt_lo;
    logic [WORD_W-1:0] cnt_hi;
    logic [WORD_W-1:0] cmp_val;
    logic [WORD_W-1:0] ctrl_word;
    logic              ctrl_wr;
    logic              cmp_wr;
    logic              ena;
    logic              flag;

    tmr_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi)
    );

    tmr_compare #(.WORD_W(WORD_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cnt_lo    (cnt_lo),
        .ctrl_wr   (ctrl_wr),
        .clr_bit   (bus_wdata[FLAG_BIT]),
        .ena_bit   (bus_wdata[ENA_BIT]),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (bus_wdata),
        .cmp_val   (cmp_val),
        .ena       (ena),
        .flag      (flag)
    );

    // Assemble the control word; unused bits read zero
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[FLAG_BIT] = flag;
        ctrl_word[ENA_BIT]  = ena;
    end

    tmr_regbus #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bus (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .ctrl_word (ctrl_word),
        .cnt_lo    (cnt_lo),
        .cnt_hi    (cnt_hi),
        .cmp_val   (cmp_val),
        .ctrl_wr   (ctrl_wr),
        .cmp_wr    (cmp_wr),
        .bus_rdata (bus_rdata)
    );

    // Drive the level interrupt from the sticky flag
    always_comb begin
        irq = flag;
    end

endmodule

// File: rtl/tmr_chk.sv
// Module tmr_chk
// Property checker for sys_tick_timer, bound to every instance of it.
// Observes counter words, compare state and the interrupt pin.
module tmr_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              ctrl_wr,
    input logic              clr_bit,
    input logic [WORD_W-1:0] cnt_lo,
    input logic [WORD_W-1:0] cnt_hi,
    input logic [WORD_W-1:0] cmp_val,
    input logic              ena,
    input logic              irq
);

    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    // R2
    lo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (cnt_lo == $past(cnt_lo) + ONE));

    // R2
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_lo));

    // R3
    hi_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (&cnt_lo)) |=> (cnt_hi == $past(cnt_hi) + ONE));

    // R3
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_en && (&cnt_lo)) |=> $stable(cnt_hi));

    // R6
    match_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena && tick_en && (cnt_lo == cmp_val)) |=> irq);

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !ena) |=> !irq);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(ctrl_wr && clr_bit)) |=> irq);

endmodule

bind sys_tick_timer tmr_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .ctrl_wr (ctrl_wr),
    .clr_bit (bus_wdata[0]),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .cmp_val (cmp_val),
    .ena     (ena),
    .irq     (irq)
);

// File: tb/tb_sys_tick_timer.sv
// Bench for sys_tick_timer: a vector table for register behaviour, then
// directed scenarios for counting, matching, priority, reset and wrap.
module tb_sys_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    // Narrow instance for observing high-word carry
    logic        s_tick = 1'b0;
    logic [7:0]  s_addr = '0;
    logic        s_re = 1'b0;
    logic [7:0]  s_rdata;
    logic        s_irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sys_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata),
        .irq(irq)
    );

    sys_tick_timer #(.ADDR_W(8), .WORD_W(8)) dut_s (
        .clk(clk), .rst_n(rst_n), .tick_en(s_tick), .bus_addr(s_addr),
        .bus_we(1'b0), .bus_wdata(8'h00), .bus_re(s_re), .bus_rdata(s_rdata),
        .irq(s_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h0C, 32'h0000_0000, 4'd1},   // R1 compare zero
        '{1'b0, 8'h00, 32'h0000_0000, 4'd1},   // R1 control zero
        '{1'b0, 8'h04, 32'h0000_0000, 4'd1},   // R1 counter zero
        '{1'b1, 8'h0C, 32'hA5A5_1234, 4'd5},   // R5 write compare
        '{1'b0, 8'h0C, 32'hA5A5_1234, 4'd5},   // R5 read compare
        '{1'b1, 8'h04, 32'hFFFF_FFFF, 4'd4},   // R4 write low word
        '{1'b0, 8'h04, 32'h0000_0000, 4'd4},   // R4 low unchanged
        '{1'b1, 8'h08, 32'h0000_1234, 4'd4},   // R4 write high word
        '{1'b0, 8'h08, 32'h0000_0000, 4'd4},   // R4 high unchanged
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 4'd10},  // R10 write all ones
        '{1'b0, 8'h00, 32'h0000_0010, 4'd10},  // R10 only enable reads
        '{1'b0, 8'h10, 32'h0000_0000, 4'd11},  // R11 beyond map
        '{1'b0, 8'h0D, 32'h0000_0000, 4'd11},  // R11 misaligned
        '{1'b1, 8'h00, 32'h0000_0000, 4'd10}   // R10 disable again
    };

    task automatic check(input int req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL R%0d %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd32(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        #2;
        d = rdata;
        re = 1'b0;
    endtask

    task automatic s_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        s_addr = a; s_re = 1'b1;
        #2;
        d = s_rdata;
        s_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic s_ticks(input int n);
        @(negedge clk);
        s_tick = 1'b1;
        repeat (n) @(negedge clk);
        s_tick = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  sv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(1, {31'b0, irq}, 32'h0, "irq after reset");

        // Table walk, counter idle
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr32(VECS[i].a, VECS[i].d);
            end else begin
                rd32(VECS[i].a, v);
                check(int'(VECS[i].req), v, VECS[i].d, "table read");
            end
        end

        // R2 counting and holding
        ticks(20);
        rd32(8'h04, v); check(2, v, 32'd20, "low after 20 ticks");
        repeat (5) @(negedge clk);
        rd32(8'h04, v); check(2, v, 32'd20, "low holds without tick");
        rd32(8'h08, v); check(3, v, 32'd0, "high without wrap");

        // R6 match and R9 interrupt
        wr32(8'h0C, 32'd23);
        wr32(8'h00, 32'h10);
        ticks(10);
        rd32(8'h00, v); check(6, v, 32'h11, "flag after match");
        check(9, {31'b0, irq}, 32'h1, "irq with flag");

        // R7 sticky and write-0 ignored
        wr32(8'h00, 32'h10);
        rd32(8'h00, v); check(7, v, 32'h11, "write 0 keeps flag");
        ticks(3);
        rd32(8'h00, v); check(7, v, 32'h11, "flag stays past match");
        wr32(8'h00, 32'h11);
        rd32(8'h00, v); check(7, v, 32'h10, "write 1 clears flag");
        check(9, {31'b0, irq}, 32'h0, "irq drops with flag");

        // R6 disabled compare raises nothing (low now 33)
        wr32(8'h00, 32'h00);
        wr32(8'h0C, 32'd35);
        ticks(5);
        rd32(8'h00, v); check(6, v, 32'h0, "no flag while disabled");

        // R8 set wins over same-edge clear (low now 38)
        wr32(8'h0C, 32'd38);
        wr32(8'h00, 32'h10);
        @(negedge clk);
        tick = 1'b1; addr = 8'h00; wdata = 32'h11; we = 1'b1;
        @(negedge clk);
        tick = 1'b0; we = 1'b0;
        rd32(8'h00, v); check(8, v, 32'h11, "set beats clear");

        // R12 one write shuts down (low now 39)
        wr32(8'h00, 32'h01);
        rd32(8'h00, v); check(12, v, 32'h0, "flag and enable cleared");
        wr32(8'h0C, 32'd41);
        ticks(4);
        rd32(8'h00, v); check(12, v, 32'h0, "no event after shutdown");
        check(12, {31'b0, irq}, 32'h0, "irq quiet after shutdown");
        rd32(8'h04, v); check(2, v, 32'd43, "low kept counting");

        // R11 read strobe low gives zero
        @(negedge clk);
        addr = 8'h0C; re = 1'b0;
        #2;
        check(11, rdata, 32'h0, "rdata idle");

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd32(8'h04, v); check(1, v, 32'h0, "low after reset");
        rd32(8'h0C, v); check(1, v, 32'h0, "compare after reset");

        // R3 carry on the narrow instance
        s_ticks(255);
        s_rd(8'h04, sv); check(3, {24'b0, sv}, 32'hFF, "narrow low before wrap");
        s_rd(8'h08, sv); check(3, {24'b0, sv}, 32'h0, "narrow high before wrap");
        s_ticks(1);
        s_rd(8'h04, sv); check(3, {24'b0, sv}, 32'h0, "narrow low wrapped");
        s_rd(8'h08, sv); check(3, {24'b0, sv}, 32'h1, "narrow high carried");
        s_ticks(3);
        s_rd(8'h08, sv); check(3, {24'b0, sv}, 32'h1, "narrow high holds");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule